// File: doc/BRIEF.md
# Trigger-Centred Sample Window Recorder

This block is one acquisition channel's capture memory in a transient recorder. Once armed, it stores every valid sample from the converter in a circular buffer at full rate. The write address wraps, so the oldest data is overwritten again and again while the block waits for an event. An external trigger pulse marks the reference point. After the trigger, the block stores a programmed number of post-trigger samples and then freezes the buffer. The buffer then holds one window that spans the reference point: the pre-trigger zone followed by the post-trigger zone.

A host unloads the frozen window offline through a simple read port. A start command points the reader at the oldest sample of the window. Each step command moves the reader to the next sample in chronological order, wrapping at the end of the buffer. Four status flags report progress. A recorder carries one instance per channel.

The controller has four states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Reset state |
| `ST_ARMED` | Capturing, waiting for a trigger |
| `ST_POST` | Capturing the post-trigger zone |
| `ST_DONE` | Frozen |

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→ARMED | Arm command |
| ARMED→POST | Trigger |
| ARMED→DONE | Trigger arriving together with a sample when the post count is 1 |
| POST→DONE | Last post-trigger sample stored |
| DONE→ARMED | Arm command |

Top module: `trig_window_capture`

## Requirements
- R1: After reset, every status output is 0, the controller is in `ST_IDLE`, and the post-trigger count equals DEPTH/2.
- R2: The arm command is accepted only in `ST_IDLE` or `ST_DONE`. Accepting it moves the controller to `ST_ARMED`, sets the write address to 0 and clears the triggered, done and partial flags. An arm command during capture has no effect.
- R3: While capturing (`ST_ARMED` or `ST_POST`), every valid sample is written at the current write address. The write address then advances by one, modulo DEPTH.
- R4: A trigger in `ST_ARMED` latches the current write address as the reference point. A sample that is valid in the trigger cycle is the first post-trigger sample. After exactly N post-trigger samples, where N is the post-trigger count, the controller enters `ST_DONE`.
- R5: A trigger in `ST_IDLE`, `ST_POST` or `ST_DONE` is ignored.
- R6: The post-trigger count is written through `cfg_wr`/`cfg_post` only in `ST_IDLE` or `ST_DONE`. Writes at other times are ignored, and a written value of 0 is stored as 1. The pre-trigger length is DEPTH−N.
- R7: In `ST_DONE` and `ST_IDLE`, incoming samples are not stored and the buffer contents stay frozen.
- R8: `rd_start` loads the read pointer with the oldest window address, which is the reference address plus N, modulo DEPTH. `rd_next` advances the pointer by one with wrap-around. `rd_data` shows the entry at the pointer combinationally, so consecutive reads return the window oldest-first.
- R9: `stat_partial` is set at the trigger if fewer than DEPTH−N samples were stored since arming. It stays set until the next accepted arm.
- R10: The status flags are set as follows:
  - `stat_armed` is 1 in `ST_ARMED` and `ST_POST`.
  - `stat_trig` is 1 in `ST_POST` and `ST_DONE`.
  - `stat_done` is 1 only in `ST_DONE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value |
| trig_in | input | 1 | External trigger pulse |
| arm | input | 1 | Arm command (pulse) |
| cfg_wr | input | 1 | Post-trigger count write strobe |
| cfg_post | input | ADDR_W | Post-trigger count value |
| rd_start | input | 1 | Reset read pointer to oldest window sample |
| rd_next | input | 1 | Advance read pointer |
| rd_data | output | DATA_W | Buffer entry at read pointer |
| stat_armed | output | 1 | Capturing |
| stat_trig | output | 1 | Trigger accepted |
| stat_done | output | 1 | Window frozen |
| stat_partial | output | 1 | Pre-trigger zone not fully valid |

## Verification
The capture path is tried with four trigger patterns:
- A long pre-trigger run, in which the buffer wraps several times, shows whether the window start is taken from the latched address.
- A trigger that coincides with a sample, compared against one that arrives between samples, separates the two counting rules for the first post-trigger sample.
- An early trigger, before the buffer has filled, exposes the partial flag and the readout alignment of a short window.
- A minimum post count of 1, reached by writing 0, checks the direct ARMED→DONE path.

Spurious triggers, arm commands and configuration writes issued mid-capture, plus samples sent after freezing, show whether their effects leak into the read-back window.

// File: rtl/twc_pkg.sv
package twc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } twc_state_e;
endpackage

// File: rtl/twc_ctrl.sv
module twc_ctrl
    import twc_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic              trig_in,
    input  logic              arm,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_post,
    input  logic [ADDR_W-1:0] wr_ptr,
    output logic              wr_en,
    output logic              wr_clear,
    output logic [ADDR_W-1:0] trig_addr,
    output logic [ADDR_W-1:0] post_len,
    output logic              stat_armed,
    output logic              stat_trig,
    output logic              stat_done,
    output logic              stat_partial
);
    localparam logic [ADDR_W:0] DEPTH_W = DEPTH[ADDR_W:0];
    localparam logic [ADDR_W-1:0] POST_RST = ADDR_W'(DEPTH / 2);

    twc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] post_len_q;
    logic [ADDR_W-1:0] left_q;
    logic [ADDR_W:0]   fill_q;
    logic [ADDR_W-1:0] trig_addr_q;
    logic              partial_q;
    logic              idle_or_done;
    logic              arm_ok;
    logic              trig_ok;
    logic [ADDR_W:0]   pre_len;

    assign idle_or_done = (state_q == ST_IDLE) || (state_q == ST_DONE);
    assign arm_ok       = arm && idle_or_done;
    assign trig_ok      = trig_in && (state_q == ST_ARMED);
    assign pre_len      = DEPTH_W - {1'b0, post_len_q};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm) state_d = ST_ARMED;
            ST_ARMED: begin
                if (trig_in) begin
                    if (smp_valid && post_len_q == ADDR_W'(1)) state_d = ST_DONE;
                    else                                       state_d = ST_POST;
                end
            end
            ST_POST:  if (smp_valid && left_q == ADDR_W'(1)) state_d = ST_DONE;
            ST_DONE:  if (arm) state_d = ST_ARMED;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        wr_en        = 1'b0;
        wr_clear     = arm_ok;
        stat_armed   = 1'b0;
        stat_trig    = 1'b0;
        stat_done    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: begin wr_en = smp_valid; stat_armed = 1'b1; end
            ST_POST:  begin wr_en = smp_valid; stat_armed = 1'b1; stat_trig = 1'b1; end
            ST_DONE:  begin stat_trig = 1'b1; stat_done = 1'b1; end
            default:  ;
        endcase
        stat_partial = partial_q;
        trig_addr    = trig_addr_q;
        post_len     = post_len_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_len_q  <= POST_RST;
            left_q      <= '0;
            fill_q      <= '0;
            trig_addr_q <= '0;
            partial_q   <= 1'b0;
        end else begin
            if (cfg_wr && idle_or_done)
                post_len_q <= (cfg_post == '0) ? ADDR_W'(1) : cfg_post;
            if (arm_ok) begin
                fill_q    <= '0;
                partial_q <= 1'b0;
            end
            if (trig_ok) begin
                trig_addr_q <= wr_ptr;
                partial_q   <= (fill_q < pre_len);
                left_q      <= post_len_q - {{(ADDR_W-1){1'b0}}, smp_valid};
            end else if (state_q == ST_ARMED && smp_valid && fill_q != DEPTH_W) begin
                fill_q <= fill_q + 1'b1;
            end
            if (state_q == ST_POST && smp_valid)
                left_q <= left_q - 1'b1;
        end
    end

    p_left_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POST) |-> (left_q != '0));
    p_ignore_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !arm) |=> (state_q == ST_IDLE));
    p_cfg_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_or_done) |=> $stable(post_len_q));
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !arm) |=> (state_q == ST_DONE));
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_armed && stat_done));
    p_post_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        post_len_q != '0);
endmodule

// File: rtl/twc_buffer.sv
module twc_buffer #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_clear,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [ADDR_W-1:0] wr_ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wr_ptr_q <= '0;
        else if (wr_clear) wr_ptr_q <= '0;
        else if (wr_en)    wr_ptr_q <= wr_ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_ptr_q] <= wr_data;
    end

    assign wr_ptr  = wr_ptr_q;
    assign rd_data = mem_q[rd_addr];

    p_wr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_clear) |=> (wr_ptr_q == $past(wr_ptr_q) + 1'b1));
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !wr_clear) |=> $stable(wr_ptr_q));
endmodule

// File: rtl/twc_reader.sv
module twc_reader #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              rd_next,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic [ADDR_W-1:0] post_len,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [ADDR_W-1:0] rd_ptr_q;
    logic [ADDR_W-1:0] oldest;

    // oldest = reference - (DEPTH - N) == reference + N modulo DEPTH
    assign oldest = trig_addr + post_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rd_ptr_q <= '0;
        else if (rd_start) rd_ptr_q <= oldest;
        else if (rd_next)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end

    assign rd_addr = rd_ptr_q;

    p_rd_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_next && !rd_start) |=> (rd_ptr_q == $past(rd_ptr_q) + 1'b1));
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_next && !rd_start) |=> $stable(rd_ptr_q));
endmodule

// File: rtl/trig_window_capture.sv
module trig_window_capture #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              trig_in,
    input  logic              arm,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_post,
    input  logic              rd_start,
    input  logic              rd_next,
    output logic [DATA_W-1:0] rd_data,
    output logic              stat_armed,
    output logic              stat_trig,
    output logic              stat_done,
    output logic              stat_partial
);
    logic              wr_en;
    logic              wr_clear;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] trig_addr;
    logic [ADDR_W-1:0] post_len;
    logic [ADDR_W-1:0] rd_addr;

    initial begin
        assert ((1 << ADDR_W) == DEPTH && DEPTH >= 4)
            else $error("DEPTH must be a power of two, at least 4");
    end

    twc_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .trig_in(trig_in),
        .arm(arm), .cfg_wr(cfg_wr), .cfg_post(cfg_post), .wr_ptr(wr_ptr),
        .wr_en(wr_en), .wr_clear(wr_clear), .trig_addr(trig_addr),
        .post_len(post_len), .stat_armed(stat_armed), .stat_trig(stat_trig),
        .stat_done(stat_done), .stat_partial(stat_partial)
    );

    twc_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_clear(wr_clear),
        .wr_data(smp_data), .rd_addr(rd_addr), .wr_ptr(wr_ptr), .rd_data(rd_data)
    );

    twc_reader #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_next(rd_next),
        .trig_addr(trig_addr), .post_len(post_len), .rd_addr(rd_addr)
    );

    p_done_needs_trig_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |-> stat_trig);
    p_partial_after_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_partial |-> stat_trig);
endmodule

// File: tb/sim_trig_window_capture.sv
`timescale 1ns/1ps
module sim_trig_window_capture;
    localparam int DATA_W = 12;
    localparam int DEPTH  = 16;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic              trig_in = 1'b0;
    logic              arm = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [ADDR_W-1:0] cfg_post = '0;
    logic              rd_start = 1'b0;
    logic              rd_next = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              stat_armed, stat_trig, stat_done, stat_partial;

    int checks = 0;
    int fails  = 0;

    // reference model, built from the requirements
    int ms = 0;        // 0 idle 1 armed 2 post 3 done
    int mn = DEPTH/2;
    int mleft = 0;
    int mpre = 0;
    bit mpart = 0;
    int hist [0:1023];
    int hcnt = 0;
    int seqv = 1;

    always #2 clk = ~clk;

    trig_window_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .trig_in(trig_in), .arm(arm), .cfg_wr(cfg_wr), .cfg_post(cfg_post),
        .rd_start(rd_start), .rd_next(rd_next), .rd_data(rd_data),
        .stat_armed(stat_armed), .stat_trig(stat_trig), .stat_done(stat_done),
        .stat_partial(stat_partial)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock with given inputs; model updated after the edge
    task automatic cyc(input bit v, input bit t, input bit a, input bit cw, input int cv);
        @(negedge clk);
        smp_valid = v; smp_data = DATA_W'(seqv); trig_in = t; arm = a;
        cfg_wr = cw; cfg_post = ADDR_W'(cv);
        @(posedge clk);
        if (cw && (ms == 0 || ms == 3)) mn = (cv == 0) ? 1 : cv;
        if (a && (ms == 0 || ms == 3)) begin
            ms = 1; hcnt = 0; mpre = 0; mpart = 0;
        end else if (ms == 1) begin
            if (t) begin
                mpart = (mpre < DEPTH - mn);
                mleft = mn;
                if (v) begin hist[hcnt] = seqv; hcnt++; mleft--; end
                ms = (mleft == 0) ? 3 : 2;
            end else if (v) begin
                hist[hcnt] = seqv; hcnt++; mpre++;
            end
        end else if (ms == 2 && v) begin
            hist[hcnt] = seqv; hcnt++; mleft--;
            if (mleft == 0) ms = 3;
        end
        if (v) seqv = (seqv % 4000) + 1;
        #1;
        smp_valid = 0; trig_in = 0; arm = 0; cfg_wr = 0;
    endtask

    task automatic chk_status(input string req);
        @(negedge clk);
        chk({req, " armed"},   stat_armed,   (ms == 1 || ms == 2));
        chk({req, " trig"},    stat_trig,    (ms == 2 || ms == 3));
        chk({req, " done"},    stat_done,    (ms == 3));
        chk({req, " partial"}, stat_partial, mpart);
    endtask

    task automatic read_window(input string req);
        int valid_n;
        valid_n = (hcnt < DEPTH) ? hcnt : DEPTH;
        @(negedge clk); rd_start = 1;
        @(negedge clk); rd_start = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i >= DEPTH - valid_n)
                chk({req, " rd_data"}, int'(rd_data), hist[hcnt - DEPTH + i] % 4096);
            rd_next = 1;
            @(negedge clk);
            rd_next = 0;
        end
    endtask

    task automatic run_samples(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
    endtask

    // R1: reset state
    task automatic t_reset;
        chk_status("R1");
        // default post count DEPTH/2 is observed by an immediate capture below
    endtask

    // R5: triggers while idle ignored
    task automatic t_idle_trig;
        cyc(1, 1, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        chk_status("R5 idle");
    endtask

    // R3 R4 R8: long run with wrap, trigger coinciding with a sample, default N
    task automatic t_long_wrap;
        cyc(0, 0, 1, 0, 0);
        chk_status("R2 arm");
        run_samples(37);
        cyc(1, 1, 0, 0, 0);
        chk_status("R4 trig");
        run_samples(mn - 2);
        chk_status("R4 before last");
        cyc(1, 0, 0, 0, 0);
        chk_status("R4 done");
        read_window("R8 R3 R1 default window");
    endtask

    // R6 R4: trigger between samples, config write and arm mid-capture ignored
    task automatic t_gap_trig;
        cyc(0, 0, 0, 1, 5);
        cyc(0, 0, 1, 0, 0);
        run_samples(20);
        cyc(0, 0, 1, 1, 9);   // R2 arm ignored, R6 cfg ignored
        chk_status("R2 rearm ignored");
        cyc(0, 1, 0, 0, 0);
        run_samples(2);
        cyc(1, 1, 0, 0, 0);   // R5 trigger during post ignored
        chk_status("R5 post trig");
        run_samples(2);
        chk_status("R4 gap done");
        read_window("R6 R4 gap window");
    endtask

    // R7: frozen after done, triggers ignored in done
    task automatic t_frozen;
        run_samples(6);
        cyc(1, 1, 0, 0, 0);
        chk_status("R7 R5 done");
        read_window("R7 frozen");
    endtask

    // R9: early trigger gives partial window
    task automatic t_partial;
        cyc(0, 0, 0, 1, 4);
        cyc(0, 0, 1, 0, 0);
        run_samples(5);
        cyc(1, 1, 0, 0, 0);
        run_samples(3);
        chk_status("R9 partial");
        read_window("R9 partial window");
        cyc(0, 0, 1, 0, 0);
        chk_status("R9 R2 cleared by arm");
    endtask

    // R6: zero count stored as one, direct done
    task automatic t_min_post;
        cyc(0, 0, 0, 0, 0);
        run_samples(DEPTH + 3);
        cyc(1, 1, 0, 0, 0);
        chk_status("R6 N stays 4");
        run_samples(3);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 1, 0, 0);
        run_samples(DEPTH);
        cyc(1, 1, 0, 0, 0);
        chk_status("R6 zero as one");
        read_window("R6 min window");
    endtask

    initial begin
        #(4.0 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_idle_trig();
        t_long_wrap();
        t_gap_trig();
        t_frozen();
        t_partial();
        t_min_post();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule